// File: doc/BRIEF.md
# Active-Low Level Interrupt Controller

This block collects up to 32 level-sensitive request lines from peripherals and combines them into one interrupt for a host processor. Software sees three 32-bit status and control words through a simple single-cycle read/write port. One word masks sources. One word shows raw pending sources. One word shows sources that are both pending and enabled. A fourth, read-only word returns the number of the lowest source that currently needs service.

Every status and mask bit uses inverted polarity: a 0 means pending or enabled, and a 1 means idle or disabled. A request word of all ones therefore means nothing needs service. Source n is bit n in every word. Pending bits have no latch and no clear-on-write. They follow the input lines, one register stage behind. To mask or unmask a source, software reads the whole mask word, changes it and writes it back.

Top module: `intc_top`

## Requirements
- R1: After reset the mask word reads 0xFFFFFFFF (every source disabled), the request word reads 0xFFFFFFFF and `irqOut` is 0.
- R2: Bit n of the pending word (offset 0x1008) reads 0 one cycle after `srcLevel[n]` is high, whatever the mask. It reads 1 again one cycle after the line drops, with no latching.
- R3: The request word (offset 0x1000) equals the bitwise OR of the pending word and the mask word.
- R4: `irqOut` is 1 exactly when some bit of the request word is 0.
- R5: A write to offset 0x1004 stores `wrData[NUM_SRC-1:0]` as the mask word. It takes effect on the next cycle and reads back unchanged.
- R6: The index word (offset 0x100C) holds, in bits [4:0], the position of the lowest 0 in the request word, and has bit 31 set. When the request word is all ones, the index word reads 0.
- R7: Writes to offsets 0x1000, 0x1008 and 0x100C change neither the mask word nor the pending word.
- R8: Read data appears on `rdData` in the cycle after `rdEn` is sampled high. An unmapped offset reads 0.
- R9: When several enabled sources are pending, the lowest bit position wins in the index word, including bit 31 when it is the only one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | NUM_SRC | Peripheral request lines, high = asserted |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset within the register window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| irqOut | output | 1 | Combined interrupt to the host, active high |

## Verification
The bench targets the inverted encoding. A design that stored or reported true-polarity bits would read 0 as the mask reset value and would raise `irqOut` with every source disabled. Masked sources must still show in the pending word; a design that ANDed rather than ORed the two words would hide them or report disabled sources as requests. The bench checks that the index picks the lowest of several sources, the boundary bit 31, and the all-ones case with the valid bit clear; an encoder scanning the wrong way would name the highest source. It also writes to the read-only offsets and to the request and pending offsets, and checks that a pending bit clears when its line drops, which catches a latched pending bit.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned OFS_REQ  = 32'h1000;
  localparam int unsigned OFS_MASK = 32'h1004;
  localparam int unsigned OFS_PEND = 32'h1008;
  localparam int unsigned OFS_IDX  = 32'h100C;
  localparam int unsigned WORD_W   = 32;

  typedef struct packed {
    logic wrMask;
    logic rdReq;
    logic rdMask;
    logic rdPend;
    logic rdIdx;
  } intcStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output intcStrobe_t       strobe
);
  logic hitReq, hitMask, hitPend, hitIdx;

  always_comb begin
    hitReq  = (addr == ADDR_W'(OFS_REQ));
    hitMask = (addr == ADDR_W'(OFS_MASK));
    hitPend = (addr == ADDR_W'(OFS_PEND));
    hitIdx  = (addr == ADDR_W'(OFS_IDX));

    strobe.wrMask = wrEn && hitMask;
    strobe.rdReq  = rdEn && hitReq;
    strobe.rdMask = rdEn && hitMask;
    strobe.rdPend = rdEn && hitPend;
    strobe.rdIdx  = rdEn && hitIdx;
  end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] reqN,
  output logic [IDX_W-1:0]   idx,
  output logic               idxValid
);
  // Scan from the top down so the last hit is the lowest zero.
  always_comb begin
    idx      = '0;
    idxValid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (!reqN[i]) begin
        idx      = IDX_W'(i);
        idxValid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [WORD_W-1:0]  wrData,
  input  intcStrobe_t        strobe,
  output logic [WORD_W-1:0]  rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] maskN,
  output logic [NUM_SRC-1:0] pendN,
  output logic [NUM_SRC-1:0] reqN,
  output logic [IDX_W-1:0]   idx,
  output logic               idxValid
);
  logic [WORD_W-1:0] reqWord, maskWord, pendWord, idxWord, rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskN <= '1;
      pendN <= '1;
    end else begin
      pendN <= ~srcLevel;
      if (strobe.wrMask) maskN <= wrData[NUM_SRC-1:0];
    end
  end

  assign reqN   = pendN | maskN;
  assign irqOut = ~&reqN;

  intc_prio_enc #(.NUM_SRC(NUM_SRC)) uEnc (
    .reqN    (reqN),
    .idx     (idx),
    .idxValid(idxValid)
  );

  always_comb begin
    reqWord  = '1;
    maskWord = '1;
    pendWord = '1;
    idxWord  = '0;
    reqWord[NUM_SRC-1:0]  = reqN;
    maskWord[NUM_SRC-1:0] = maskN;
    pendWord[NUM_SRC-1:0] = pendN;
    idxWord[IDX_W-1:0]    = idx;
    idxWord[WORD_W-1]     = idxValid;

    rdNext = '0;
    unique case (1'b1)
      strobe.rdReq:  rdNext = reqWord;
      strobe.rdMask: rdNext = maskWord;
      strobe.rdPend: rdNext = pendWord;
      strobe.rdIdx:  rdNext = idxWord;
      default:       rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqOut
);
  intcStrobe_t        strobe;
  logic [NUM_SRC-1:0] maskN, pendN, reqN;
  logic [IDX_W-1:0]   idx;
  logic               idxValid;

  intc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strobe(strobe)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .srcLevel(srcLevel),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .maskN   (maskN),
    .pendN   (pendN),
    .reqN    (reqN),
    .idx     (idx),
    .idxValid(idxValid)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wrData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] maskN,
  input logic [NUM_SRC-1:0] pendN,
  input logic [NUM_SRC-1:0] reqN,
  input logic [IDX_W-1:0]   idx,
  input logic               idxValid
);
  logic maskWrite;
  assign maskWrite = wrEn && (addr == ADDR_W'(32'h1004));

  a_r2_pend_tracks_line: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> pendN == ~$past(srcLevel));

  a_r4_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskN != '1));

  a_r5_mask_write: assert property (@(posedge clk) disable iff (!rstN)
    maskWrite |=> maskN == $past(wrData[NUM_SRC-1:0]));

  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrite |=> $stable(maskN));

  a_r6_valid_matches_irq: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == idxValid);

  a_r9_idx_is_zero_bit: assert property (@(posedge clk) disable iff (!rstN)
    idxValid |-> !reqN[idx]);
endmodule

bind intc_top intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .srcLevel(srcLevel),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .irqOut  (irqOut),
  .maskN   (maskN),
  .pendN   (pendN),
  .reqN    (reqN),
  .idx     (idx),
  .idxValid(idxValid)
);

// File: tb/intc_top_test.sv
module intc_top_test;
  localparam int NUM_SRC = 32;
  localparam int ADDR_W  = 16;
  localparam logic [ADDR_W-1:0] A_REQ  = 16'h1000;
  localparam logic [ADDR_W-1:0] A_MASK = 16'h1004;
  localparam logic [ADDR_W-1:0] A_PEND = 16'h1008;
  localparam logic [ADDR_W-1:0] A_IDX  = 16'h100C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_SRC-1:0] srcLevel = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut;

  int vecCount = 0;
  int missCount = 0;
  logic [31:0] modelMask = '1;

  always #4 clk = ~clk;

  intc_top #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expIdx(input logic [31:0] req);
    for (int i = 0; i < 32; i++)
      if (!req[i]) return 32'h8000_0000 | 32'(i);
    return 32'h0;
  endfunction

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(negedge clk);
    srcLevel = v;
    @(negedge clk);
  endtask

  task automatic checkAll(input string tag, input logic [31:0] src);
    logic [31:0] d, req;
    req = ~src | modelMask;
    busRead(A_PEND, d); check({tag, " R2 pending"}, d, ~src);
    busRead(A_REQ,  d); check({tag, " R3 request"}, d, req);
    busRead(A_IDX,  d); check({tag, " R6 R9 index"}, d, expIdx(req));
    check({tag, " R4 irqOut"}, {31'b0, irqOut}, {31'b0, req != '1});
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(A_MASK, d); check("R1 mask after reset", d, 32'hFFFF_FFFF);
    busRead(A_REQ, d);  check("R1 request after reset", d, 32'hFFFF_FFFF);
    busRead(A_IDX, d);  check("R6 index idle", d, 32'h0);
    check("R1 irqOut after reset", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testMaskedPending();
    setSrc(32'h0000_0018);
    checkAll("masked", 32'h0000_0018);
  endtask

  task automatic testMaskWrite();
    logic [31:0] d;
    modelMask = ~32'h0000_0010;
    busWrite(A_MASK, modelMask);
    busRead(A_MASK, d); check("R5 mask readback", d, modelMask);
    checkAll("unmask4", 32'h0000_0018);
  endtask

  task automatic testPriority();
    modelMask = 32'h0;
    busWrite(A_MASK, modelMask);
    setSrc(32'h0003_00C0);
    checkAll("prio4", 32'h0003_00C0);
    setSrc(32'h0003_0080);
    checkAll("drop6", 32'h0003_0080);
    setSrc(32'h8000_0000);
    checkAll("bit31", 32'h8000_0000);
    setSrc(32'h0);
    checkAll("idle", 32'h0);
  endtask

  task automatic testIgnoredWrites();
    logic [31:0] d;
    modelMask = 32'hFFFF_F0FF;
    busWrite(A_MASK, modelMask);
    setSrc(32'h0000_0600);
    busWrite(A_REQ, 32'h0);
    busWrite(A_PEND, 32'hFFFF_FFFF);
    busWrite(A_IDX, 32'h0);
    busRead(A_MASK, d); check("R7 mask unchanged", d, modelMask);
    checkAll("R7 after ignored writes", 32'h0000_0600);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busRead(16'h1010, d); check("R8 unmapped 0x1010", d, 32'h0);
    busRead(16'h0000, d); check("R8 unmapped 0x0000", d, 32'h0);
  endtask

  task automatic testPatterns();
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int k = 0; k < 6; k++) begin
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      modelMask = ~(s ^ 32'h0F0F_3C3C);
      busWrite(A_MASK, modelMask);
      setSrc(s & 32'hF0F0_0FF0);
      checkAll("R3 pattern", s & 32'hF0F0_0FF0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaskedPending();
    testMaskWrite();
    testPriority();
    testIgnoredWrites();
    testUnmapped();
    testPatterns();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecCount++;
    missCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule